// File: doc/BRIEF.md
# Byte-Mapped Interval Timer

This block is a small interval timer with a byte-wide register interface. It holds two 16-bit down-counters, called counter 0 and counter 2. Each counter has its own data port, and a shared control port chooses a counter and sets its counting mode. Software loads a count in two byte writes, low byte first. The counter starts when the high byte arrives and counts down once per cycle in which the tick enable is high. The tick enable stands for a counting rate of about 1.19 MHz.

When a counter reaches its terminal count it gives a one-cycle expiry pulse. In one-shot mode (mode 0) the counter then stops and raises a done bit in its status byte, and software polls that byte through the control port. In any other mode the counter reloads its programmed count and keeps running. The block supports only the low-then-high byte access scheme and binary counting. Any access or command outside that scheme sets a sticky error flag and does not change the configuration.

Top module: `pit_timer`

## Requirements
- R1: After synchronous reset the error flag is 0, the status byte reads 0x00, no expiry pulse appears, and both counters stay idle.
- R2: Port address 0 is the counter 0 data port, 2 is the counter 2 data port, and 3 is the control port on write and the counter 2 status port on read. A write to address 1, or a read of any address other than 3, sets the error flag.
- R3: In a control write, bits 7:6 select the counter (0, 1 or 2). The value 3 is a read-back command: it sets the error flag and changes nothing.
- R4: A control write with bits 5:4 other than 2'b11, or with bit 0 set, sets the error flag and leaves every stored mode unchanged.
- R5: A valid control write stores bits 3:1 as the mode of the selected counter. Selecting counter 1 is accepted without error and has no other effect.
- R6: A count is loaded by two data-port writes, low byte first, then high byte. A counter stays idle until the high byte completes a load.
- R7: One half-loaded flag is shared by both data ports. A low byte written to one port followed by a high byte written to the other port loads and starts the second counter.
- R8: A counter loaded with N expires on the Nth tick-enable cycle after the load. A count of 0 means 65536 ticks, and cycles without tick enable do not count.
- R9: In mode 0, expiry stops the counter and its status byte becomes 0x20 (bit 5 set).
- R10: In any nonzero mode, expiry reloads the programmed count and the counter keeps expiring every N ticks.
- R11: Completing a load clears that counter's status byte to 0x00.
- R12: Each terminal count gives an expiry pulse exactly one clock wide, in the cycle after the clock edge that takes the final tick.
- R13: The error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 2 | Port address |
| wdata_i | input | 8 | Write data byte |
| tick_i | input | 1 | Counting tick enable |
| rdata_o | output | 8 | Read data: counter 2 status when address is 3, else 0 |
| expire_o | output | 2 | Expiry pulses; bit 0 is counter 0, bit 1 is counter 2 |
| err_o | output | 1 | Sticky error flag |

## Verification
The high byte write and the tick that counts both take effect at the same clock edge. An expiry pulse and the new status byte are therefore due one cycle after the edge that takes the Nth tick. The error flag is due one cycle after the bad access, and the read bus follows the address input in the same cycle. The bench drives inputs on falling edges and counts expiry pulses with a monitor that samples on falling edges. It waits one extra falling edge after each burst of ticks before it compares the pulse counts, so a pulse is never checked in the cycle it is produced. The read bus is sampled shortly after the address is set.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 16;
    localparam int SPAN_W   = CNT_W + 1;
    localparam int MODE_W   = 3;
    localparam int NUM_CTR  = 2;
    localparam int DONE_BIT = 5;

    typedef enum logic [1:0] {
        PORT_C0  = 2'd0,
        PORT_GAP = 2'd1,
        PORT_C2  = 2'd2,
        PORT_CTL = 2'd3
    } port_e;

    localparam logic [1:0] ACC_LOHI = 2'b11;
    localparam logic [1:0] SEL_RDBK = 2'b11;
    localparam logic [MODE_W-1:0] MODE_ONESHOT = '0;

    typedef struct packed {
        logic [1:0]        sel;
        logic [1:0]        acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctl_word_t;

    typedef struct packed {
        logic             go;
        logic [CNT_W-1:0] value;
    } load_t;

    function automatic logic ctl_ok(ctl_word_t w);
        return (w.sel != SEL_RDBK) && (w.acc == ACC_LOHI) && !w.bcd;
    endfunction

    function automatic logic [SPAN_W-1:0] span_of(logic [CNT_W-1:0] v);
        return (v == '0) ? (SPAN_W'(1) << CNT_W) : {1'b0, v};
    endfunction

    // slot i maps to counter number 2*i (0 and 2); the same code is its data port
    function automatic logic [1:0] code_of(int i);
        return 2'(2 * i);
    endfunction

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [1:0]          addr_i,
    input  logic [BYTE_W-1:0]   wdata_i,
    output load_t               load_o [NUM_CTR],
    output logic [MODE_W-1:0]   mode_o [NUM_CTR],
    output logic                err_o
);

    logic              half_q;
    logic [BYTE_W-1:0] lo_q;
    logic              err_q;
    logic [MODE_W-1:0] mode_q [NUM_CTR];
    ctl_word_t         cw;
    logic              data_wr;
    logic              ctl_wr;
    logic              bad;

    assign cw      = ctl_word_t'(wdata_i);
    assign ctl_wr  = wr_en_i && (addr_i == PORT_CTL);
    assign data_wr = wr_en_i && ((addr_i == PORT_C0) || (addr_i == PORT_C2));
    assign bad     = (ctl_wr && !ctl_ok(cw))
                   || (wr_en_i && (addr_i == PORT_GAP))
                   || (rd_en_i && (addr_i != PORT_CTL));

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
            lo_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            if (bad) begin
                err_q <= 1'b1;
            end
            if (data_wr) begin
                if (half_q) begin
                    half_q <= 1'b0;
                end else begin
                    half_q <= 1'b1;
                    lo_q   <= wdata_i;
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        localparam logic [1:0] CODE = code_of(i);

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q[i] <= MODE_ONESHOT;
            end else if (ctl_wr && ctl_ok(cw) && (cw.sel == CODE)) begin
                mode_q[i] <= cw.mode;
            end
        end

        assign load_o[i].go    = wr_en_i && (addr_i == CODE) && half_q;
        assign load_o[i].value = {wdata_i, lo_q};
        assign mode_o[i]       = mode_q[i];

        // R4: a rejected control word leaves the stored mode as it was
        a_r4_bad_ctl_keeps_mode: assert property (@(posedge clk) disable iff (rst)
            (ctl_wr && !ctl_ok(cw)) |=> $stable(mode_q[i]));
    end

    assign err_o = err_q;

    // R13: error flag is sticky
    a_r13_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R7: every data-port byte flips the shared half-loaded flag
    a_r7_half_toggles: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (half_q != $past(half_q)));

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  load_t             load_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              expire_o,
    output logic              done_o
);

    logic              run_q;
    logic              exp_q;
    logic              done_q;
    logic [SPAN_W-1:0] cnt_q;
    logic [SPAN_W-1:0] rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            exp_q  <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            rel_q  <= '0;
        end else begin
            exp_q <= 1'b0;
            if (load_i.go) begin
                rel_q  <= span_of(load_i.value);
                cnt_q  <= span_of(load_i.value);
                run_q  <= 1'b1;
                done_q <= 1'b0;
            end else if (run_q && tick_i) begin
                if (cnt_q == SPAN_W'(1)) begin
                    exp_q <= 1'b1;
                    if (mode_i == MODE_ONESHOT) begin
                        run_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        cnt_q <= rel_q;
                    end
                end else begin
                    cnt_q <= cnt_q - SPAN_W'(1);
                end
            end
        end
    end

    assign expire_o = exp_q;
    assign done_o   = done_q;

    // R12: a pulse only follows a counted tick of a running counter
    a_r12_expire_after_tick: assert property (@(posedge clk) disable iff (rst)
        exp_q |-> $past(run_q && tick_i));

    // R12: pulse is one cycle wide
    a_r12_single_cycle: assert property (@(posedge clk) disable iff (rst)
        exp_q |=> !exp_q);

    // R9: one-shot expiry halts and marks done
    a_r9_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
        (exp_q && ($past(mode_i) == MODE_ONESHOT)) |-> (!run_q && done_q));

    // R10: periodic expiry reloads and keeps running
    a_r10_periodic_reload: assert property (@(posedge clk) disable iff (rst)
        (exp_q && ($past(mode_i) != MODE_ONESHOT)) |-> (run_q && cnt_q == rel_q));

    // R11: a completed load clears status and starts the counter
    a_r11_start_clears: assert property (@(posedge clk) disable iff (rst)
        $past(load_i.go) |-> (!done_q && run_q));

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [1:0]        addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              tick_i,
    output logic [7:0]        rdata_o,
    output logic [1:0]        expire_o,
    output logic              err_o
);

    load_t             load   [NUM_CTR];
    logic [MODE_W-1:0] mode   [NUM_CTR];
    logic [NUM_CTR-1:0] done;
    localparam int     STAT_SLOT = NUM_CTR - 1;

    pit_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .load_o  (load),
        .mode_o  (mode),
        .err_o   (err_o)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        pit_counter u_ctr (
            .clk      (clk),
            .rst      (rst),
            .tick_i   (tick_i),
            .load_i   (load[i]),
            .mode_i   (mode[i]),
            .expire_o (expire_o[i]),
            .done_o   (done[i])
        );

        // R9: done bit only rises together with that counter's expiry pulse
        a_r9_done_with_expiry: assert property (@(posedge clk) disable iff (rst)
            $rose(done[i]) |-> expire_o[i]);
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == PORT_CTL) begin
            rdata_o[DONE_BIT] = done[STAT_SLOT];
        end
    end

endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // {control byte, count}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h30, 16'd3},
        {8'h34, 16'd5},
        {8'hB0, 16'd4},
        {8'hB6, 16'd2},
        {8'h32, 16'd1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic       tick = 1'b0;
    logic [7:0] rdata;
    logic [1:0] expire;
    logic       err;

    int checks = 0;
    int fails  = 0;
    int ex0 = 0;
    int ex1 = 0;
    int wide = 0;
    logic [1:0] prev_exp = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_timer dut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .tick_i(tick),
        .rdata_o(rdata), .expire_o(expire), .err_o(err)
    );

    always @(negedge clk) begin
        if (expire[0]) ex0++;
        if (expire[1]) ex1++;
        if ((expire & prev_exp) != 2'b00) wide++;
        prev_exp = expire;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_status(output int v);
        @(negedge clk);
        rd_en = 1'b1; addr = 2'd3;
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(input logic [1:0] port, input logic [15:0] v);
        wr(port, v[7:0]);
        wr(port, v[15:8]);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int b0, b1, v;
        // R1 reset state
        do_reset();
        rd_status(v);
        check("R1 status", v, 0);
        check("R1 err", int'(err), 0);
        b0 = ex0; b1 = ex1;
        ticks(20);
        check("R1 idle c0", ex0 - b0, 0);
        check("R1 idle c2", ex1 - b1, 0);

        // table: mode/count/counter combinations (R5 R8 R9 R10 R12)
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0]  cw;
            logic [15:0] cnt;
            logic [1:0]  port;
            int per, st, base;
            cw = VEC[i][23:16];
            cnt = VEC[i][15:0];
            port = cw[7:6];
            per = (cw[3:1] != 3'd0) ? 1 : 0;
            do_reset();
            wr(2'd3, cw);
            load(port, cnt);
            base = (port == 2'd0) ? ex0 : ex1;
            ticks(int'(cnt) - 1);
            check("R8 not before N", ((port == 2'd0) ? ex0 : ex1) - base, 0);
            ticks(1);
            check("R12 pulse at N", ((port == 2'd0) ? ex0 : ex1) - base, 1);
            ticks(int'(cnt));
            check(per ? "R10 periodic" : "R9 oneshot stop",
                  ((port == 2'd0) ? ex0 : ex1) - base, per ? 2 : 1);
            if (port == 2'd2) begin
                rd_status(st);
                check("R9 status", st, per ? 0 : 32);
            end
            check("R5 no err", int'(err), 0);
        end
        check("R12 pulse width", wide, 0);

        // R6: idle until high byte
        do_reset();
        wr(2'd3, 8'h34);
        wr(2'd0, 8'd3);
        b0 = ex0;
        ticks(10);
        check("R6 idle half", ex0 - b0, 0);
        wr(2'd0, 8'd0);
        ticks(3);
        check("R6 start", ex0 - b0, 1);

        // R7: shared half flag across ports
        do_reset();
        wr(2'd3, 8'hB4);
        b0 = ex0; b1 = ex1;
        wr(2'd0, 8'd2);
        wr(2'd2, 8'd0);
        ticks(2);
        check("R7 c2 started", ex1 - b1, 1);
        check("R7 c0 idle", ex0 - b0, 0);

        // R8: no tick, no count
        do_reset();
        wr(2'd3, 8'h30);
        load(2'd0, 16'd1);
        b0 = ex0;
        repeat (8) @(negedge clk);
        check("R8 tick gated", ex0 - b0, 0);

        // R11: reload clears status
        do_reset();
        wr(2'd3, 8'hB0);
        load(2'd2, 16'd1);
        ticks(1);
        rd_status(v);
        check("R11 done first", v, 32);
        load(2'd2, 16'd5);
        rd_status(v);
        check("R11 cleared", v, 0);

        // R4: bad access mode flagged, mode kept
        do_reset();
        wr(2'd3, 8'h34);
        load(2'd0, 16'd2);
        wr(2'd3, 8'h10);
        check("R4 err acc", int'(err), 1);
        b0 = ex0;
        ticks(4);
        check("R4 mode kept", ex0 - b0, 2);
        do_reset();
        wr(2'd3, 8'h35);
        check("R4 err bcd", int'(err), 1);

        // R3: read-back command; R13 sticky
        do_reset();
        wr(2'd3, 8'hC0);
        check("R3 readback err", int'(err), 1);
        repeat (5) @(negedge clk);
        wr(2'd3, 8'h34);
        check("R13 sticky", int'(err), 1);

        // R5: counter 1 select accepted
        do_reset();
        wr(2'd3, 8'h76);
        check("R5 c1 no err", int'(err), 0);

        // R2: address map errors
        do_reset();
        wr(2'd1, 8'h00);
        check("R2 gap write", int'(err), 1);
        do_reset();
        @(negedge clk); rd_en = 1'b1; addr = 2'd0;
        @(negedge clk); rd_en = 1'b0;
        @(negedge clk);
        check("R2 bad read", int'(err), 1);
        do_reset();
        rd_status(v);
        @(negedge clk);
        check("R2 good read", int'(err), 0);

        // R8: zero means 65536
        do_reset();
        wr(2'd3, 8'h34);
        load(2'd0, 16'd0);
        b0 = ex0;
        ticks(65535);
        check("R8 zero early", ex0 - b0, 0);
        ticks(1);
        check("R8 zero span", ex0 - b0, 1);

        finish_run();
    end

endmodule